// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block gathers level-sensitive interrupt lines and decides, for every CPU, which one to present next. Software programs it through a plain 32-bit register bus that carries a CPU number with each access. Through that bus it sets a global forwarding switch, enables each interrupt, gives each interrupt a priority byte, and picks which CPUs receive each shared interrupt. It can also raise software interrupts on a chosen set of CPUs.

Interrupt IDs 0 to 31 are private to each CPU. IDs 0 to 15 are software interrupts that are latched per CPU. IDs 16 to 31 are per-CPU level lines. IDs 32 and up are shared level lines. For each CPU the block shows a request and an interrupt ID. The CPU takes the interrupt with an acknowledge pulse and finishes it with an end-of-interrupt pulse. Each CPU has a two-state handshake machine. In `CPU_READY` the CPU may be offered an interrupt. On an acknowledge that is granted (*take*), the machine moves to `CPU_SERVICING`, latches the ID and marks the interrupt active. On an end-of-interrupt (*finish*), the machine returns to `CPU_READY` and clears the active mark. An acknowledge in `CPU_SERVICING` and an end-of-interrupt in `CPU_READY` are ignored.

Top module: `irq_distributor`

## Requirements
- R1: After reset, no CPU sees a request. The control register, all enable words and all priority bytes read 0.
- R2: The control register is at 0x000 and its bit 0 is the forwarding switch. While that bit is 0, `irq_req` is 0 for every CPU and acknowledges have no effect.
- R3: The read-only type register at 0x004 returns NUM_IRQ/32-1 in bits [4:0], which is 1 for 64 lines. Writes to it are ignored.
- R4: The set view is at 0x100 plus 4 per word, and word w covers IDs 32w to 32w+31. Writing a 1 enables that ID. Zero bits leave the enable bit unchanged. The set view and the clear view at 0x180 both read back the enable word.
- R5: Writing a 1 to a bit of the clear view at 0x180 plus 4 per word disables that ID. Zero bits leave the enable bit unchanged.
- R6: Enable, pending and active state for IDs 0 to 31 is kept separately for each CPU. The bus CPU number selects which copy is accessed, and one CPU's settings do not affect another CPU.
- R7: The priority of ID n is the byte at address 0x400+n, in bits [8*(n%4)+7 : 8*(n%4)] of its word. It reads back as written.
- R8: The CPU target byte of shared ID n is at 0x800+n, and its bit c routes the interrupt to CPU c. For private IDs, the target bytes read as the requesting CPU's own bit, and writes to them are ignored.
- R9: A write to 0xF00 with bit 16+c set and an ID in bits [3:0] makes that software ID pending on CPU c. Acknowledging it on CPU c clears that pending bit.
- R10: A CPU is offered the interrupt that is enabled, pending, not active and targets it, with the numerically lowest priority value. Ties go to the lowest ID. `irq_id` carries that ID and reads 0 when there is no request.
- R11: A granted acknowledge moves the CPU to `CPU_SERVICING`. Its request drops until end-of-interrupt, and the taken ID is offered to no CPU while it is active.
- R12: End-of-interrupt returns the CPU to `CPU_READY` and clears active. A line that is still high is offered again.
- R13: If two CPUs acknowledge the same shared ID in the same cycle, the lower-numbered CPU takes it. The other CPU stays in `CPU_READY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_cpu | input | CPU_W | CPU number of the current bus access |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_lines | input | NUM_IRQ-32 | Shared level lines; bit k is ID 32+k |
| ppi_lines | input | NUM_CPU*16 | Per-CPU private level lines; bit 16c+k is ID 16+k of CPU c |
| cpu_ack | input | NUM_CPU | Acknowledge pulse per CPU |
| cpu_eoi | input | NUM_CPU | End-of-interrupt pulse per CPU |
| irq_req | output | NUM_CPU | Interrupt request per CPU |
| irq_id | output | NUM_CPU*ID_W | Offered ID per CPU; field c is bits [c*ID_W +: ID_W] |

## Verification
The assertions check several properties on every clock cycle. Nothing is offered while forwarding is off. A granted acknowledge drops the request in the next cycle. The latched ID stays stable while the CPU is servicing. No CPU ever has more than one private interrupt active. A software interrupt write sets the pending bit it names. A clear-view write removes the bits it names, and a set-view write adds them. Only the bench scenarios can show the choice of winner when priorities tie, the per-CPU separation of private state, re-offering after end-of-interrupt, and the lower-CPU rule on simultaneous acknowledges.

// File: rtl/dist_pkg.sv
package dist_pkg;
    localparam int PRIV_IRQS = 32;
    localparam int SGI_IRQS  = 16;
    localparam int PRIO_W    = 8;

    localparam int OFF_CTRL  = 'h000;
    localparam int OFF_TYPE  = 'h004;
    localparam int OFF_SETEN = 'h100;
    localparam int OFF_CLREN = 'h180;
    localparam int OFF_PRIO  = 'h400;
    localparam int OFF_TGT   = 'h800;
    localparam int OFF_SGI   = 'hF00;

    typedef enum logic {
        CPU_READY     = 1'b0,
        CPU_SERVICING = 1'b1
    } cpu_state_e;
endpackage

// File: rtl/dist_regs.sv
module dist_regs
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int SPI_N    = NUM_IRQ - PRIV_IRQS,
    localparam int EN_WORDS = NUM_IRQ / 32,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [CPU_W-1:0]                      bus_cpu,
    input  logic                                  bus_we,
    input  logic [11:0]                           bus_addr,
    input  logic [31:0]                           bus_wdata,
    output logic [31:0]                           bus_rdata,
    output logic                                  fwd_en,
    output logic [NUM_CPU-1:0][PRIV_IRQS-1:0]     priv_en,
    output logic [SPI_N-1:0]                      spi_en,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]        prio,
    output logic [SPI_N-1:0][NUM_CPU-1:0]         tgt,
    output logic [NUM_CPU-1:0][SGI_IRQS-1:0]      sgi_set
);
    int   addr_i, en_idx, pr_idx, tg_idx;
    logic hit_ctrl, hit_type, hit_set, hit_clr, hit_en, hit_prio, hit_tgt, hit_sgi;
    logic [7:0] own_mask;

    always_comb begin
        addr_i   = int'(bus_addr);
        hit_ctrl = (addr_i == OFF_CTRL);
        hit_type = (addr_i == OFF_TYPE);
        hit_set  = (addr_i >= OFF_SETEN) && (addr_i < OFF_SETEN + 4*EN_WORDS);
        hit_clr  = (addr_i >= OFF_CLREN) && (addr_i < OFF_CLREN + 4*EN_WORDS);
        hit_en   = hit_set || hit_clr;
        hit_prio = (addr_i >= OFF_PRIO) && (addr_i < OFF_PRIO + NUM_IRQ);
        hit_tgt  = (addr_i >= OFF_TGT) && (addr_i < OFF_TGT + NUM_IRQ);
        hit_sgi  = (addr_i == OFF_SGI);
        en_idx   = hit_set ? (addr_i - OFF_SETEN) / 4 : (addr_i - OFF_CLREN) / 4;
        pr_idx   = (addr_i - OFF_PRIO) / 4;
        tg_idx   = (addr_i - OFF_TGT) / 4;
        own_mask = 8'(1) << bus_cpu;
    end

    // Write side: enables use set/clear views, priority and targets are byte packed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_en  <= 1'b0;
            priv_en <= '0;
            spi_en  <= '0;
            prio    <= '0;
            tgt     <= '0;
        end else if (bus_we) begin
            if (hit_ctrl) fwd_en <= bus_wdata[0];
            if (hit_en && en_idx == 0) begin
                if (hit_set) priv_en[bus_cpu] <= priv_en[bus_cpu] | bus_wdata;
                else         priv_en[bus_cpu] <= priv_en[bus_cpu] & ~bus_wdata;
            end
            for (int k = 1; k < EN_WORDS; k++) begin
                if (hit_en && en_idx == k) begin
                    if (hit_set) spi_en[(k-1)*32 +: 32] <= spi_en[(k-1)*32 +: 32] | bus_wdata;
                    else         spi_en[(k-1)*32 +: 32] <= spi_en[(k-1)*32 +: 32] & ~bus_wdata;
                end
            end
            if (hit_prio) begin
                for (int b = 0; b < 4; b++) prio[pr_idx*4 + b] <= bus_wdata[8*b +: 8];
            end
            if (hit_tgt) begin
                for (int b = 0; b < 4; b++) begin
                    if (tg_idx*4 + b >= PRIV_IRQS)
                        tgt[tg_idx*4 + b - PRIV_IRQS] <= bus_wdata[8*b +: NUM_CPU];
                end
            end
        end
    end

    // Software interrupt pulses, one per CPU and software ID
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int k = 0; k < SGI_IRQS; k++) begin
                sgi_set[c][k] = bus_we && hit_sgi && bus_wdata[16+c] && (bus_wdata[3:0] == 4'(k));
            end
        end
    end

    // Read side
    always_comb begin
        int n;
        bus_rdata = '0;
        n = 0;
        if (hit_ctrl) begin
            bus_rdata[0] = fwd_en;
        end else if (hit_type) begin
            bus_rdata[4:0] = 5'(EN_WORDS - 1);
        end else if (hit_en) begin
            if (en_idx == 0) bus_rdata = priv_en[bus_cpu];
            for (int k = 1; k < EN_WORDS; k++) begin
                if (en_idx == k) bus_rdata = spi_en[(k-1)*32 +: 32];
            end
        end else if (hit_prio) begin
            for (int b = 0; b < 4; b++) bus_rdata[8*b +: 8] = prio[pr_idx*4 + b];
        end else if (hit_tgt) begin
            for (int b = 0; b < 4; b++) begin
                n = tg_idx*4 + b;
                if (n < PRIV_IRQS) bus_rdata[8*b +: 8] = own_mask;
                else               bus_rdata[8*b +: NUM_CPU] = tgt[n - PRIV_IRQS];
            end
        end
    end

    AST_SET_VIEW_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_set && en_idx == 0) |=>
        ((priv_en[$past(bus_cpu)] & $past(bus_wdata)) == $past(bus_wdata))); // R4

    if (EN_WORDS > 1) begin : g_clr_chk
        AST_CLEAR_VIEW_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && hit_clr && en_idx == 1) |=>
            ((spi_en[31:0] & $past(bus_wdata)) == 32'd0)); // R5
    end
endmodule

// File: rtl/dist_select.sv
module dist_select
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int ID_W = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]             elig,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    output logic                           found,
    output logic [ID_W-1:0]                best_id
);
    logic [PRIO_W-1:0] best_p;

    // Linear scan: strict compare keeps the lowest ID on ties
    always_comb begin
        found   = 1'b0;
        best_id = '0;
        best_p  = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!found || prio[i] < best_p)) begin
                found   = 1'b1;
                best_p  = prio[i];
                best_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/dist_cpu_if.sv
module dist_cpu_if
    import dist_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fwd_en,
    input  logic            cand_valid,
    input  logic [ID_W-1:0] cand_id,
    input  logic            take,
    input  logic            eoi,
    output logic            irq_req,
    output logic [ID_W-1:0] irq_id,
    output logic [ID_W-1:0] svc_id,
    output logic            eoi_fire
);
    cpu_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CPU_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CPU_READY:     if (take) state_d = CPU_SERVICING;
            CPU_SERVICING: if (eoi)  state_d = CPU_READY;
            default:       state_d = CPU_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            svc_id <= '0;
        else if (state_q == CPU_READY && take) svc_id <= cand_id;
    end

    always_comb begin
        irq_req  = (state_q == CPU_READY) && fwd_en && cand_valid;
        irq_id   = irq_req ? cand_id : '0;
        eoi_fire = (state_q == CPU_SERVICING) && eoi;
    end

    AST_SVC_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CPU_SERVICING && !eoi) |=> $stable(svc_id)); // R11
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int SPI_N  = NUM_IRQ - PRIV_IRQS,
    localparam int ID_W   = $clog2(NUM_IRQ),
    localparam int SPI_IW = $clog2(SPI_N),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CPU_W-1:0]        bus_cpu,
    input  logic                    bus_we,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [SPI_N-1:0]        spi_lines,
    input  logic [NUM_CPU*16-1:0]   ppi_lines,
    input  logic [NUM_CPU-1:0]      cpu_ack,
    input  logic [NUM_CPU-1:0]      cpu_eoi,
    output logic [NUM_CPU-1:0]      irq_req,
    output logic [NUM_CPU*ID_W-1:0] irq_id
);
    logic                                 fwd_en;
    logic [NUM_CPU-1:0][PRIV_IRQS-1:0]    priv_en;
    logic [SPI_N-1:0]                     spi_en;
    logic [NUM_IRQ-1:0][PRIO_W-1:0]       prio;
    logic [SPI_N-1:0][NUM_CPU-1:0]        tgt;
    logic [NUM_CPU-1:0][SGI_IRQS-1:0]     sgi_set;

    logic [NUM_CPU-1:0][SGI_IRQS-1:0]     sgi_pend_q;
    logic [NUM_CPU-1:0][PRIV_IRQS-1:0]    priv_act_q;
    logic [SPI_N-1:0]                     spi_act_q;

    logic [NUM_CPU-1:0][NUM_IRQ-1:0]      elig;
    logic [NUM_CPU-1:0]                   cand_valid, grant, eoi_fire;
    logic [NUM_CPU-1:0][ID_W-1:0]         cand_id, id_w, svc_id;

    dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fwd_en(fwd_en), .priv_en(priv_en), .spi_en(spi_en), .prio(prio),
        .tgt(tgt), .sgi_set(sgi_set)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_comb begin
            for (int i = 0; i < SGI_IRQS; i++)
                elig[c][i] = priv_en[c][i] && sgi_pend_q[c][i] && !priv_act_q[c][i];
            for (int i = SGI_IRQS; i < PRIV_IRQS; i++)
                elig[c][i] = priv_en[c][i] && ppi_lines[c*16 + i - SGI_IRQS] && !priv_act_q[c][i];
            for (int i = PRIV_IRQS; i < NUM_IRQ; i++)
                elig[c][i] = spi_en[i-PRIV_IRQS] && spi_lines[i-PRIV_IRQS]
                           && !spi_act_q[i-PRIV_IRQS] && tgt[i-PRIV_IRQS][c];
        end

        dist_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
            .elig(elig[c]), .prio(prio), .found(cand_valid[c]), .best_id(cand_id[c])
        );

        dist_cpu_if #(.ID_W(ID_W)) u_if (
            .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .cand_valid(cand_valid[c]),
            .cand_id(cand_id[c]), .take(grant[c]), .eoi(cpu_eoi[c]),
            .irq_req(irq_req[c]), .irq_id(id_w[c]), .svc_id(svc_id[c]),
            .eoi_fire(eoi_fire[c])
        );

        AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            grant[c] |=> !irq_req[c]); // R11

        AST_PRIV_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(priv_act_q[c]) <= 1); // R11

        AST_SGI_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && int'(bus_addr) == OFF_SGI && bus_wdata[16+c])
            |=> sgi_pend_q[c][$past(bus_wdata[3:0])]); // R9
    end

    assign irq_id = id_w;

    // Lower-numbered CPU wins a shared ID acknowledged by several CPUs at once
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            grant[c] = cpu_ack[c] && irq_req[c];
            for (int l = 0; l < c; l++) begin
                if (cpu_ack[l] && irq_req[l] && id_w[l] == id_w[c]
                    && id_w[c] >= ID_W'(PRIV_IRQS))
                    grant[c] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgi_pend_q <= '0;
            priv_act_q <= '0;
            spi_act_q  <= '0;
        end else begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (eoi_fire[c]) begin
                    if (svc_id[c] < ID_W'(PRIV_IRQS)) priv_act_q[c][svc_id[c][4:0]] <= 1'b0;
                    else spi_act_q[SPI_IW'(svc_id[c] - ID_W'(PRIV_IRQS))] <= 1'b0;
                end
                if (grant[c]) begin
                    if (id_w[c] < ID_W'(PRIV_IRQS)) begin
                        priv_act_q[c][id_w[c][4:0]] <= 1'b1;
                        if (id_w[c] < ID_W'(SGI_IRQS)) sgi_pend_q[c][id_w[c][3:0]] <= 1'b0;
                    end else begin
                        spi_act_q[SPI_IW'(id_w[c] - ID_W'(PRIV_IRQS))] <= 1'b1;
                    end
                end
                for (int k = 0; k < SGI_IRQS; k++) begin
                    if (sgi_set[c][k]) sgi_pend_q[c][k] <= 1'b1;
                end
            end
        end
    end

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (irq_req == '0)); // R2
endmodule

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
    localparam int NUM_IRQ = 64;
    localparam int NUM_CPU = 2;
    localparam int ID_W    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  bus_cpu = '0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] spi_lines = '0;
    logic [31:0] ppi_lines = '0;
    logic [1:0]  cpu_ack = '0;
    logic [1:0]  cpu_eoi = '0;
    logic [1:0]  irq_req;
    logic [11:0] irq_id;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    irq_distributor #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) uut (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_lines(spi_lines), .ppi_lines(ppi_lines), .cpu_ack(cpu_ack),
        .cpu_eoi(cpu_eoi), .irq_req(irq_req), .irq_id(irq_id)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL R1 watchdog: actual=%0d cycles expected=<50000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_cpu = 1'(cpu); bus_addr = 12'(addr); bus_wdata = data; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input int cpu, input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_cpu = 1'(cpu); bus_addr = 12'(addr); bus_we = 1'b0;
        #1 data = bus_rdata;
    endtask

    task automatic pulse(input logic [1:0] ack, input logic [1:0] eoi);
        @(negedge clk);
        cpu_ack = ack; cpu_eoi = eoi;
        @(negedge clk);
        cpu_ack = '0; cpu_eoi = '0;
        #1;
    endtask

    function automatic logic [ID_W-1:0] id_of(input int c);
        return irq_id[c*ID_W +: ID_W];
    endfunction

    // Reference pick over shared IDs: lowest priority value, then lowest ID
    function automatic int ref_pick(input logic [7:0] p [32], input logic [31:0] lines);
        int best = -1;
        for (int k = 0; k < 32; k++) begin
            if (lines[k] && (best < 0 || p[k] < p[best])) best = k;
        end
        return best;
    endfunction

    initial begin
        logic [31:0] d;
        logic [7:0]  sh_p [32];
        int          exp_k;
        void'($urandom(32'd2718));

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;

        // R1 reset state
        check("R1 req", 32'(irq_req), 32'd0);
        rd(0, 'h000, d); check("R1 ctrl", d, 32'd0);
        rd(0, 'h104, d); check("R1 enable", d, 32'd0);
        rd(0, 'h404, d); check("R1 prio", d, 32'd0);

        // R3 type register
        rd(0, 'h004, d); check("R3 type", d, 32'd1);
        wr(0, 'h004, 32'h1F);
        rd(0, 'h004, d); check("R3 type after write", d, 32'd1);

        // R4 set view, R5 clear view
        wr(0, 'h104, 32'h5);
        rd(0, 'h104, d); check("R4 set view", d, 32'h5);
        rd(0, 'h184, d); check("R4 clear view readback", d, 32'h5);
        wr(0, 'h104, 32'h2);
        rd(0, 'h104, d); check("R4 zero bits kept", d, 32'h7);
        wr(0, 'h184, 32'h1);
        rd(0, 'h104, d); check("R5 clear", d, 32'h6);

        // R7 priority bytes
        wr(0, 'h420, 32'h40302010);
        rd(0, 'h420, d); check("R7 prio readback", d, 32'h40302010);

        // R8 targets
        wr(0, 'h820, 32'h02010101);
        rd(0, 'h820, d); check("R8 target readback", d, 32'h02010101);
        rd(1, 'h800, d); check("R8 private target cpu1", d, 32'h02020202);
        wr(1, 'h800, 32'h0);
        rd(0, 'h800, d); check("R8 private target write ignored", d, 32'h01010101);

        // R2 forwarding switch
        spi_lines = 32'h6;
        #1;
        check("R2 off no req", 32'(irq_req), 32'd0);
        pulse(2'b01, 2'b00);
        wr(0, 'h000, 32'h1);
        check("R2 ack ignored while off", 32'(irq_req[0]), 32'd1);
        check("R10 lower prio wins", 32'(id_of(0)), 32'd33);
        check("R8 untargeted cpu1", 32'(irq_req[1]), 32'd0);

        // R10 tie and reorder
        wr(0, 'h420, 32'h40202010);
        check("R10 tie lowest id", 32'(id_of(0)), 32'd33);
        wr(0, 'h420, 32'h401F2010);
        check("R10 lower value", 32'(id_of(0)), 32'd34);
        wr(0, 'h420, 32'h40302010);

        // R11 acknowledge, R12 end-of-interrupt
        pulse(2'b01, 2'b00);
        check("R11 req drops while servicing", 32'(irq_req[0]), 32'd0);
        pulse(2'b00, 2'b01);
        check("R12 re-offered", 32'(irq_req[0]), 32'd1);
        check("R12 id", 32'(id_of(0)), 32'd33);

        // R6 banking, R9 software interrupts
        wr(0, 'h100, 32'h8);
        rd(1, 'h100, d); check("R6 cpu1 bank", d, 32'd0);
        rd(0, 'h100, d); check("R6 cpu0 bank", d, 32'h8);
        wr(0, 'hF00, 32'h0003_0003);
        check("R9 sgi cpu0", 32'(id_of(0)), 32'd3);
        check("R6 cpu1 not enabled", 32'(irq_req[1]), 32'd0);
        wr(1, 'h100, 32'h8);
        check("R9 sgi cpu1 req", 32'(irq_req[1]), 32'd1);
        check("R9 sgi cpu1 id", 32'(id_of(1)), 32'd3);
        pulse(2'b01, 2'b00);
        pulse(2'b00, 2'b01);
        check("R9 sgi cleared by ack", 32'(id_of(0)), 32'd33);
        pulse(2'b10, 2'b00);
        pulse(2'b00, 2'b10);
        check("R9 cpu1 sgi cleared", 32'(irq_req[1]), 32'd0);

        // R13 simultaneous acknowledge
        wr(0, 'h820, 32'h02010301);
        check("R13 cpu1 offered", 32'(id_of(1)), 32'd33);
        pulse(2'b11, 2'b00);
        check("R13 cpu0 took it", 32'(irq_req[0]), 32'd0);
        check("R11 active hidden from cpu1", 32'(irq_req[1]), 32'd0);
        pulse(2'b00, 2'b01);
        check("R13 cpu1 stayed ready", 32'(irq_req[1]), 32'd1);
        check("R13 cpu1 id", 32'(id_of(1)), 32'd33);

        // R10 random priorities and lines, shared IDs to cpu0 only
        wr(0, 'h180, 32'hFFFF_FFFF);
        wr(1, 'h180, 32'hFFFF_FFFF);
        wr(0, 'h104, 32'hFFFF_FFFF);
        for (int w = 0; w < 8; w++) wr(0, 'h820 + 4*w, 32'h01010101);
        for (int it = 0; it < 40; it++) begin
            for (int w = 0; w < 8; w++) begin
                for (int b = 0; b < 4; b++) sh_p[w*4+b] = 8'($urandom_range(0, 3));
                wr(0, 'h420 + 4*w, {sh_p[w*4+3], sh_p[w*4+2], sh_p[w*4+1], sh_p[w*4]});
            end
            spi_lines = (it % 8 == 0) ? 32'd0 : ($urandom & $urandom);
            #1;
            exp_k = ref_pick(sh_p, spi_lines);
            check("R10 random req", 32'(irq_req[0]), (exp_k >= 0) ? 32'd1 : 32'd0);
            check("R10 random id", 32'(id_of(0)), (exp_k >= 0) ? 32'(exp_k + 32) : 32'd0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule